// File: doc/BRIEF.md
# Sequential Endpoint Buffer Allocator

This block owns the buffer-memory layout of a sixteen-endpoint device controller: two control endpoints (control OUT at index 0, control IN at index 1) and fourteen data endpoints (indices 2 to 15). Software writes one configuration word per endpoint. Each word carries an enable bit, a transfer type (isochronous or bulk/interrupt), a direction, a single- or double-buffer choice and a size code. The block shadows the words as they arrive.

Only an unbroken pass over all sixteen indices, lowest first, starts a layout computation. That computation walks the endpoints one per cycle and packs their regions back to back in a shared memory of parameterised capacity. At the end of the pass it publishes the base, length, enable, type and direction of every endpoint. Whenever the layout of any endpoint moved, it also raises a flush on every endpoint, because stored packet data can no longer be trusted.

A bus-reset pulse disables every endpoint, flushes all of them and forgets any partial sequence. The buffer memory itself and all packet handling sit outside this block.

Top module: `ep_fifo_allocator`

## Requirements
- R1: A configuration write is accepted in order when its index equals the next expected index, which starts at 0. Only an in-order write to index 15 starts a layout pass: `busy` rises on the following cycle and never rises otherwise.
- R2: A write whose index is neither the expected one nor 0 is discarded and resets the expected index to 0. A write to index 0 is always accepted and restarts the sequence at 1. A sequence broken in this way starts no pass.
- R3: Indices 0 and 1 ignore their written payload. Both use enabled, bulk/interrupt, single-buffered, size code `CTRL_SIZE_CODE`; index 0 has direction OUT (0) and index 1 has direction IN (1).
- R4: The configuration word is bit 6 enable, bit 5 isochronous, bit 4 direction IN, bit 3 double buffer, bits 2:0 size code. The region size is 2^(`MIN_SIZE_LOG2` + code) bytes. `epIso` and `epDirIn` publish bits 5 and 4 of the last completed sequence.
- R5: Regions are packed in index order. Each endpoint's base equals the sum of the lengths of all lower indices. A disabled endpoint gets length 0 at the current running base.
- R6: A double-buffered enabled endpoint gets twice its region size.
- R7: An enabled endpoint whose region would end past `CAPACITY` stays disabled with length 0 and sets `overflow` for that pass. Later endpoints that still fit are placed. `overflow` clears at the start of the next pass.
- R8: `busy` stays high for exactly 16 cycles per pass. `epEnable` reads all zero while `busy` is high.
- R9: In the cycle after `busy` falls, `epFlush` is all ones for one cycle if any endpoint's enable or length differs from the previous layout. It stays all zero if none differs.
- R10: A `busReset` pulse clears every enable and length, pulses `epFlush` all ones on the next cycle, aborts a running pass and resets the expected index to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration write strobe |
| cfgIdx | input | 4 | Endpoint index of the write |
| cfgData | input | 7 | Configuration word (R4 layout) |
| busReset | input | 1 | Bus-reset pulse |
| epBase | output | 16 x ADDR_W | Region base per endpoint |
| epLen | output | 16 x ADDR_W | Region length per endpoint |
| epEnable | output | 16 | Endpoint enabled and placed |
| epIso | output | 16 | Endpoint is isochronous |
| epDirIn | output | 16 | Endpoint direction is IN |
| epFlush | output | 16 | One-cycle invalidate of buffered data |
| busy | output | 1 | Layout pass in progress |
| overflow | output | 1 | Last pass ran out of capacity |

## Verification
The assertions assume that no configuration write arrives while `busy` is high. Such a write is dropped by the control and would otherwise confuse the link between sequence and pass. The stimulus only writes between passes: it waits for `busy` to fall before starting the next sequence. Bus-reset pulses are placed only between writes, never in the same cycle as one, and the bench computes every expected layout on its own from the configuration words it sent.

// File: rtl/epalloc_pkg.sv
package epalloc_pkg;
  localparam int EP_COUNT    = 16;
  localparam int EP_IDX_W    = $clog2(EP_COUNT);
  localparam int SIZE_CODE_W = 3;
  localparam logic [EP_IDX_W-1:0] LAST_EP = EP_IDX_W'(EP_COUNT - 1);

  typedef struct packed {
    logic                   enable;
    logic                   iso;
    logic                   dirIn;
    logic                   dbl;
    logic [SIZE_CODE_W-1:0] sizeCode;
  } epCfg_t;

  typedef struct packed {
    logic                stage;
    logic [EP_IDX_W-1:0] stageIdx;
    logic                step;
    logic [EP_IDX_W-1:0] stepIdx;
    logic                busReset;
  } allocStrobes_t;
endpackage

// File: rtl/epalloc_ctrl.sv
module epalloc_ctrl
  import epalloc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgValid,
  input  logic [EP_IDX_W-1:0] cfgIdx,
  input  logic                busResetIn,
  output allocStrobes_t       strb,
  output logic                busy
);
  logic [EP_IDX_W-1:0] seqNext;
  logic [EP_IDX_W-1:0] stepIdx;
  logic                accept;

  assign accept = cfgValid && !busy && !busResetIn &&
                  (cfgIdx == '0 || cfgIdx == seqNext);

  always_ff @(posedge clk) begin
    if (!rstN || busResetIn) begin
      seqNext <= '0;
      busy    <= 1'b0;
      stepIdx <= '0;
    end else if (busy) begin
      if (stepIdx == LAST_EP) busy <= 1'b0;
      else                    stepIdx <= stepIdx + 1'b1;
    end else if (cfgValid) begin
      if (accept) begin
        if (cfgIdx == LAST_EP) begin
          seqNext <= '0;
          busy    <= 1'b1;
          stepIdx <= '0;
        end else begin
          seqNext <= cfgIdx + 1'b1;
        end
      end else begin
        seqNext <= '0;
      end
    end
  end

  always_comb begin
    strb.stage    = accept;
    strb.stageIdx = cfgIdx;
    strb.step     = busy;
    strb.stepIdx  = stepIdx;
    strb.busReset = busResetIn;
  end

  // R1
  pass_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cfgValid && cfgIdx == LAST_EP));

  // R2
  seq_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !busy && !busResetIn && cfgIdx != '0 && cfgIdx != seqNext)
      |=> (seqNext == '0 && !busy));

  // R8
  pass_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stepIdx != LAST_EP && !busResetIn)
      |=> (busy && stepIdx == EP_IDX_W'($past(stepIdx) + 1'b1)));
endmodule

// File: rtl/epalloc_datapath.sv
module epalloc_datapath
  import epalloc_pkg::*;
#(
  parameter int CAPACITY       = 2048,
  parameter int MIN_SIZE_LOG2  = 3,
  parameter int CTRL_SIZE_CODE = 3,
  localparam int ADDR_W = $clog2(CAPACITY + 1)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  allocStrobes_t                      strb,
  input  epCfg_t                             stagePayload,
  output logic [EP_COUNT-1:0][ADDR_W-1:0]    baseQ,
  output logic [EP_COUNT-1:0][ADDR_W-1:0]    lenQ,
  output logic [EP_COUNT-1:0]                enQ,
  output logic [EP_COUNT-1:0]                isoQ,
  output logic [EP_COUNT-1:0]                dirQ,
  output logic                               flushQ,
  output logic                               overflowQ
);
  localparam int NEED_W = MIN_SIZE_LOG2 + (1 << SIZE_CODE_W) + 1;
  localparam int SUM_W  = ((NEED_W > ADDR_W) ? NEED_W : ADDR_W) + 1;

  epCfg_t            shadow [EP_COUNT];
  logic [SUM_W-1:0]  cursor;
  logic              changedAcc;

  epCfg_t            cur;
  logic [SUM_W-1:0]  sizeB, need, cursorBase, endAddr;
  logic [ADDR_W-1:0] newLen;
  logic              fits, newEn, changed, accPrev, firstStep;

  function automatic epCfg_t withFixed(input logic [EP_IDX_W-1:0] idx, input epCfg_t p);
    epCfg_t r;
    r = p;
    if (idx < EP_IDX_W'(2)) begin
      r.enable   = 1'b1;
      r.iso      = 1'b0;
      r.dirIn    = idx[0];
      r.dbl      = 1'b0;
      r.sizeCode = SIZE_CODE_W'(CTRL_SIZE_CODE);
    end
    return r;
  endfunction

  always_comb begin
    cur        = shadow[strb.stepIdx];
    firstStep  = (strb.stepIdx == '0);
    sizeB      = SUM_W'(1) << (SUM_W'(MIN_SIZE_LOG2) + SUM_W'(cur.sizeCode));
    need       = !cur.enable ? '0 : (cur.dbl ? (sizeB << 1) : sizeB);
    cursorBase = firstStep ? '0 : cursor;
    endAddr    = cursorBase + need;
    fits       = (endAddr <= SUM_W'(CAPACITY));
    newEn      = cur.enable && fits;
    newLen     = newEn ? need[ADDR_W-1:0] : '0;
    changed    = (newEn != enQ[strb.stepIdx]) || (newLen != lenQ[strb.stepIdx]);
    accPrev    = !firstStep && changedAcc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < EP_COUNT; i++) shadow[i] <= '0;
      baseQ      <= '0;
      lenQ       <= '0;
      enQ        <= '0;
      isoQ       <= '0;
      dirQ       <= '0;
      cursor     <= '0;
      changedAcc <= 1'b0;
      flushQ     <= 1'b0;
      overflowQ  <= 1'b0;
    end else begin
      flushQ <= 1'b0;
      if (strb.busReset) begin
        enQ    <= '0;
        lenQ   <= '0;
        flushQ <= 1'b1;
      end else begin
        if (strb.stage)
          shadow[strb.stageIdx] <= withFixed(strb.stageIdx, stagePayload);
        if (strb.step) begin
          baseQ[strb.stepIdx] <= cursorBase[ADDR_W-1:0];
          lenQ[strb.stepIdx]  <= newLen;
          enQ[strb.stepIdx]   <= newEn;
          isoQ[strb.stepIdx]  <= cur.iso;
          dirQ[strb.stepIdx]  <= cur.dirIn;
          cursor              <= cursorBase + SUM_W'(newLen);
          changedAcc          <= accPrev || changed;
          overflowQ           <= (!firstStep && overflowQ) || (cur.enable && !fits);
          if (strb.stepIdx == LAST_EP) flushQ <= accPrev || changed;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < EP_COUNT; g++) begin : gFitChk
      // R7
      region_fits_chk: assert property (@(posedge clk) disable iff (!rstN)
        enQ[g] |-> (SUM_W'(baseQ[g]) + SUM_W'(lenQ[g]) <= SUM_W'(CAPACITY)));
    end
  endgenerate

  // R10
  bus_reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.busReset |=> (enQ == '0 && lenQ == '0 && flushQ));
endmodule

// File: rtl/ep_fifo_allocator.sv
module ep_fifo_allocator
  import epalloc_pkg::*;
#(
  parameter int CAPACITY       = 2048,
  parameter int MIN_SIZE_LOG2  = 3,
  parameter int CTRL_SIZE_CODE = 3,
  localparam int ADDR_W = $clog2(CAPACITY + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgValid,
  input  logic [EP_IDX_W-1:0]             cfgIdx,
  input  logic [$bits(epCfg_t)-1:0]       cfgData,
  input  logic                            busReset,
  output logic [EP_COUNT-1:0][ADDR_W-1:0] epBase,
  output logic [EP_COUNT-1:0][ADDR_W-1:0] epLen,
  output logic [EP_COUNT-1:0]             epEnable,
  output logic [EP_COUNT-1:0]             epIso,
  output logic [EP_COUNT-1:0]             epDirIn,
  output logic [EP_COUNT-1:0]             epFlush,
  output logic                            busy,
  output logic                            overflow
);
  allocStrobes_t       strb;
  logic [EP_COUNT-1:0] enQ;
  logic                flushQ;

  epalloc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgValid   (cfgValid),
    .cfgIdx     (cfgIdx),
    .busResetIn (busReset),
    .strb       (strb),
    .busy       (busy)
  );

  epalloc_datapath #(
    .CAPACITY       (CAPACITY),
    .MIN_SIZE_LOG2  (MIN_SIZE_LOG2),
    .CTRL_SIZE_CODE (CTRL_SIZE_CODE)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .stagePayload (epCfg_t'(cfgData)),
    .baseQ        (epBase),
    .lenQ         (epLen),
    .enQ          (enQ),
    .isoQ         (epIso),
    .dirQ         (epDirIn),
    .flushQ       (flushQ),
    .overflowQ    (overflow)
  );

  assign epEnable = enQ & {EP_COUNT{~busy}};
  assign epFlush  = {EP_COUNT{flushQ}};

  // R9
  flush_after_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (epFlush != '0) |-> !busy);

  // R8
  hidden_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (epEnable == '0));
endmodule

// File: tb/ep_fifo_allocator_bench.sv
module ep_fifo_allocator_bench;
  localparam int EPN = 16, CAP = 2048, AW = 12, CTRL_CODE = 3, MINLOG = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, cfgValid, busReset;
  logic [3:0] cfgIdx;
  logic [6:0] cfgData;
  logic [EPN-1:0][AW-1:0] epBase, epLen;
  logic [EPN-1:0] epEnable, epIso, epDirIn, epFlush;
  logic busy, overflow;

  ep_fifo_allocator u_ep_fifo_allocator (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .busReset(busReset), .epBase(epBase), .epLen(epLen), .epEnable(epEnable),
    .epIso(epIso), .epDirIn(epDirIn), .epFlush(epFlush), .busy(busy), .overflow(overflow));

  int nChecks = 0, nFail = 0, cycles = 0;
  logic [6:0] cfgTab [EPN];
  int expBase [EPN], expLen [EPN], expEn [EPN], expIso [EPN], expDir [EPN];
  int prevEn [EPN], prevLen [EPN];
  int expOvf, expFlush;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [6:0] mk(input int en, input int iso, input int dir, input int dbl, input int code);
    return {en[0], iso[0], dir[0], dbl[0], code[2:0]};
  endfunction

  // Layout model built from R3..R7, flush prediction from R9
  task automatic model();
    int cur = 0;
    expOvf = 0;
    expFlush = 0;
    for (int i = 0; i < EPN; i++) begin
      int en, iso, dir, dbl, code, need, e, len;
      if (i < 2) begin en = 1; iso = 0; dir = i; dbl = 0; code = CTRL_CODE; end
      else begin
        en = cfgTab[i][6]; iso = cfgTab[i][5]; dir = cfgTab[i][4];
        dbl = cfgTab[i][3]; code = cfgTab[i][2:0];
      end
      need = en ? ((1 << (MINLOG + code)) * (dbl ? 2 : 1)) : 0;
      e = (en != 0 && cur + need <= CAP) ? 1 : 0;
      if (en != 0 && e == 0) expOvf = 1;
      len = e ? need : 0;
      expBase[i] = cur; expLen[i] = len; expEn[i] = e; expIso[i] = iso; expDir[i] = dir;
      if (e != prevEn[i] || len != prevLen[i]) expFlush = 1;
      cur += len;
    end
  endtask

  task automatic writeOne(input int idx, input logic [6:0] d);
    @(negedge clk);
    cfgValid = 1'b1; cfgIdx = idx[3:0]; cfgData = d;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  task automatic compareLayout(input string tag);
    for (int i = 0; i < EPN; i++) begin
      chk(int'(epBase[i]) == expBase[i], "R5 base", int'(epBase[i]), expBase[i]);
      chk(int'(epLen[i]) == expLen[i], "R6/R7 length", int'(epLen[i]), expLen[i]);
      chk(int'(epEnable[i]) == expEn[i], "R7 enable", int'(epEnable[i]), expEn[i]);
      chk(int'(epIso[i]) == expIso[i], "R4/R3 iso", int'(epIso[i]), expIso[i]);
      chk(int'(epDirIn[i]) == expDir[i], "R4/R3 dir", int'(epDirIn[i]), expDir[i]);
    end
    chk(int'(overflow) == expOvf, {"R7 overflow ", tag}, int'(overflow), expOvf);
    for (int i = 0; i < EPN; i++) begin prevEn[i] = expEn[i]; prevLen[i] = expLen[i]; end
  endtask

  // Write all 16 in order, then follow the pass (R1, R8, R9)
  task automatic runPass(input string tag);
    int busyCnt = 0;
    bit hidden = 1;
    model();
    for (int i = 0; i < EPN; i++) begin
      if (i == EPN - 1) chk(busy == 1'b0, "R1 no busy before last", int'(busy), 0);
      writeOne(i, cfgTab[i]);
    end
    while (busy && busyCnt < 40) begin
      if (epEnable != '0) hidden = 0;
      busyCnt++;
      @(negedge clk);
    end
    chk(busyCnt == 16, {"R8 busy length ", tag}, busyCnt, 16);
    chk(hidden, "R8 enables hidden", int'(hidden), 1);
    chk(int'(epFlush) == (expFlush ? 16'hFFFF : 0), {"R9 flush ", tag}, int'(epFlush), expFlush ? 16'hFFFF : 0);
    compareLayout(tag);
    @(negedge clk);
    chk(epFlush == '0, "R9 flush one cycle", int'(epFlush), 0);
  endtask

  task automatic noPassFor(input int n, input string req);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (busy) seen = 1; end
    chk(!seen, req, int'(seen), 0);
  endtask

  initial begin
    rstN = 1'b0; cfgValid = 1'b0; busReset = 1'b0; cfgIdx = '0; cfgData = '0;
    for (int i = 0; i < EPN; i++) begin prevEn[i] = 0; prevLen[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "reset busy", int'(busy), 0);
    chk(epEnable == '0, "reset enable", int'(epEnable), 0);
    chk(epFlush == '0, "reset flush", int'(epFlush), 0);
    chk(overflow == 1'b0, "reset overflow", int'(overflow), 0);

    // Small layout, garbage in control payloads (R3)
    for (int i = 0; i < EPN; i++) cfgTab[i] = mk(1, i % 2, (i >> 1) % 2, 0, 0);
    cfgTab[0] = 7'h2F; cfgTab[1] = 7'h07;
    runPass("first");
    runPass("repeat");           // identical layout: R9 no flush

    // Sweep of size codes and buffering patterns (R5, R6, R7)
    for (int c = 0; c < 8; c++)
      for (int dp = 0; dp < 2; dp++) begin
        for (int i = 2; i < EPN; i++)
          cfgTab[i] = mk(((i + c) % 4) != 0, i % 2, (i >> 1) % 2, (i + dp) % 2, (c + (i % 3)) % 8);
        cfgTab[0] = mk(0, 1, 1, 1, c); cfgTab[1] = mk(0, 1, 0, 1, 7 - c);
        runPass($sformatf("sweep%0d_%0d", c, dp));
      end

    // R2: broken sequence never starts a pass, layout stays
    for (int i = 0; i < 6; i++) writeOne(i, cfgTab[i]);
    writeOne(7, cfgTab[7]);
    for (int i = 8; i < EPN; i++) writeOne(i, cfgTab[i]);
    noPassFor(6, "R2 out-of-order no pass");
    compareLayout("R2 unchanged");

    // R2: index 0 restarts mid-sequence, then a full pass runs
    for (int i = 0; i < 4; i++) writeOne(i, cfgTab[i]);
    for (int i = 2; i < EPN; i++) cfgTab[i] = mk(1, 0, 1, 0, 1);
    runPass("R2 restart");

    // R10: bus reset clears enables and pulses flush
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
    chk(epEnable == '0, "R10 enables cleared", int'(epEnable), 0);
    chk(int'(epFlush) == 16'hFFFF, "R10 flush pulse", int'(epFlush), 16'hFFFF);
    for (int i = 0; i < EPN; i++) chk(epLen[i] == '0, "R10 length cleared", int'(epLen[i]), 0);
    for (int i = 0; i < EPN; i++) begin prevEn[i] = 0; prevLen[i] = 0; end

    // R10: bus reset forgets a partial sequence
    for (int i = 0; i < 8; i++) writeOne(i, cfgTab[i]);
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
    for (int i = 8; i < EPN; i++) writeOne(i, cfgTab[i]);
    noPassFor(6, "R10 tracker reset");

    // R10: bus reset aborts a running pass
    for (int i = 0; i < EPN; i++) writeOne(i, cfgTab[i]);
    repeat (3) @(negedge clk);
    busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
    chk(busy == 1'b0, "R10 pass aborted", int'(busy), 0);
    chk(epEnable == '0, "R10 enables after abort", int'(epEnable), 0);
    for (int i = 0; i < EPN; i++) begin prevEn[i] = 0; prevLen[i] = 0; end
    runPass("after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule